// File: doc/BRIEF.md
# Sine-table PWM generator

This block drives a pulse-width-modulated output whose duty cycle follows a stored list of samples. A free-running up-counter defines the PWM period; at every counter wrap the next sample from an internal table becomes the compare value for the main channel. After an external RC low-pass filter, a table holding one cycle of a sine wave produces an analog sine whose frequency is set by the table length and the period.

A second channel shares the counter and produces a fixed duty from its own compare register. Each time the table has been played through, a one-cycle event pulse is raised and an auxiliary output flips, so that software can rewrite samples or change the waveform. Configuration uses a simple write port that selects one of four targets. Period and compare changes are held back until the next wrap, so a period in progress is never shortened or stretched.

Top module: `sinepwm_top`

## Requirements
- R1: The internal counter counts from 0 up to the active period value P and restarts at 0 on the following clock, so every PWM period lasts P+1 clocks.
- R2: After reset the active period is 255, giving 256 clocks per PWM period.
- R3: With an active compare value C where 1 <= C <= P, the output is high for the first C clocks of each period and low for the remaining P+1-C clocks.
- R4: A write to the period, to the fixed compare or to a table sample never changes an output within the period in progress; new period and compare values take effect only from the next wrap.
- R5: C = 0 gives an output that stays low for the whole period (clear wins over set); C > P gives an output that stays high for the whole period.
- R6: At each wrap the main channel loads the table entry at the current index, and the index then advances; after the entry whose index equals (or exceeds) the programmed last index, it returns to 0. Table lengths from 1 to 256 entries are supported.
- R7: `tableEnd` is high for exactly one clock, beginning one clock after the wrap that ends the period in which the last table entry was in use.
- R8: `passToggle` changes state together with every `tableEnd` pulse and at no other time.
- R9: `pwmFixed` follows the rules of R3 and R5 with the fixed compare register, using the same counter.
- R10: While reset is asserted and during the first period afterwards, all outputs are low; the first table sample is loaded at the first wrap.
- R11: A write is taken when `wrEn` is high at a rising clock edge; `wrSel` = 0 writes the period from `wrData[7:0]`, 1 writes the fixed compare from `wrData`, 2 writes the last table index from `wrData[7:0]`, 3 writes `wrData` into the table at `wrAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 2 | Write target select |
| wrAddr | input | 8 | Table index for sample writes |
| wrData | input | 9 | Write value |
| pwmMain | output | 1 | Table-driven PWM output |
| pwmFixed | output | 1 | Fixed-duty PWM output |
| tableEnd | output | 1 | One-cycle end-of-table event |
| passToggle | output | 1 | Flips on every end-of-table event |

## Verification
Every output is a register, so a wrap that occurs at clock edge k shows on `pwmMain`, `pwmFixed`, `tableEnd` and `passToggle` right after edge k, and a write taken at edge k can first influence an output after the first wrap edge that follows it. The bench steps a cycle model of the requirements at each rising edge, using the inputs that were stable at that edge, and queues the four expected output values; the monitor pops one entry per cycle and compares at the falling edge, half a clock after the edge that produced the value. Stimulus is driven only on falling edges.

// File: rtl/sinepwm_pkg.sv
package sinepwm_pkg;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_FIXED  = 2'd1,
    SEL_LAST   = 2'd2,
    SEL_SAMPLE = 2'd3
  } wrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrap;     // counter is at the period value this cycle
    logic passEnd;  // this wrap closes the period that used the last entry
  } pwmStrobe_t;

endpackage

// File: rtl/sinepwm_ctrl.sv
module sinepwm_ctrl
  import sinepwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodAct,
  input  logic [IDX_W-1:0] lastIdx,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] nextCnt,
  output logic [IDX_W-1:0] rdIdx,
  output pwmStrobe_t       strobe
);

  logic wrapNow;
  logic atLast;
  logic lastInUse;

  assign wrapNow = (cnt == periodAct);
  assign nextCnt = wrapNow ? '0 : cnt + 1'b1;
  // a shrunk table may leave the index beyond the new end
  assign atLast  = (rdIdx >= lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else begin
      cnt <= nextCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx     <= '0;
      lastInUse <= 1'b0;
    end else if (wrapNow) begin
      rdIdx     <= atLast ? '0 : rdIdx + 1'b1;
      lastInUse <= atLast;
    end
  end

  assign strobe.wrap    = wrapNow;
  assign strobe.passEnd = wrapNow & lastInUse;

endmodule

// File: rtl/sinepwm_datapath.sv
module sinepwm_datapath
  import sinepwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CMP_W = 9,
  parameter int IDX_W = 8,
  parameter int DEPTH = 256
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [1:0]            wrSel,
  input  logic [IDX_W-1:0]      wrAddr,
  input  logic [CMP_W-1:0]      wrData,
  input  pwmStrobe_t            strobe,
  input  logic [IDX_W-1:0]      rdIdx,
  output logic [CNT_W-1:0]      periodAct,
  output logic [IDX_W-1:0]      lastIdx,
  output logic [CMP_W-1:0]      cmpA,
  output logic [CMP_W-1:0]      cmpB,
  output logic [1:0][CMP_W-1:0] cmpNext,
  output logic                  tableEnd,
  output logic                  passToggle
);

  localparam logic [CNT_W-1:0] PERIOD_RST = {CNT_W{1'b1}};
  localparam logic [IDX_W-1:0] LAST_RST   = IDX_W'(DEPTH - 1);

  wrSel_e           selNow;
  logic [CNT_W-1:0] periodReg;
  logic [CMP_W-1:0] fixedReg;
  logic [CMP_W-1:0] sampleMem [DEPTH];
  logic [CMP_W-1:0] fetched;

  assign selNow  = wrSel_e'(wrSel);
  assign fetched = sampleMem[rdIdx];

  always_ff @(posedge clk) begin
    if (wrEn && selNow == SEL_SAMPLE) begin
      sampleMem[wrAddr] <= wrData;
    end
  end

  // programmed values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= PERIOD_RST;
      fixedReg  <= '0;
      lastIdx   <= LAST_RST;
    end else if (wrEn) begin
      case (selNow)
        SEL_PERIOD: periodReg <= wrData[CNT_W-1:0];
        SEL_FIXED:  fixedReg  <= wrData;
        SEL_LAST:   lastIdx   <= wrData[IDX_W-1:0];
        default:    ;
      endcase
    end
  end

  // values in effect, refreshed only at the wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodAct <= PERIOD_RST;
      cmpA      <= '0;
      cmpB      <= '0;
    end else if (strobe.wrap) begin
      periodAct <= periodReg;
      cmpA      <= fetched;
      cmpB      <= fixedReg;
    end
  end

  assign cmpNext[0] = strobe.wrap ? fetched  : cmpA;
  assign cmpNext[1] = strobe.wrap ? fixedReg : cmpB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tableEnd   <= 1'b0;
      passToggle <= 1'b0;
    end else begin
      tableEnd   <= strobe.passEnd;
      passToggle <= passToggle ^ strobe.passEnd;
    end
  end

endmodule

// File: rtl/sinepwm_chan.sv
module sinepwm_chan #(
  parameter int CNT_W = 8,
  parameter int CMP_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setNow,
  input  logic [CNT_W-1:0] nextCnt,
  input  logic [CMP_W-1:0] cmpNext,
  output logic             pwm
);

  logic clrNow;

  // clear when the coming count reaches the compare value in effect then
  assign clrNow = ({{(CMP_W-CNT_W){1'b0}}, nextCnt} == cmpNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwm <= 1'b0;
    end else if (clrNow) begin
      pwm <= 1'b0;  // clear has priority over set
    end else if (setNow) begin
      pwm <= 1'b1;
    end
  end

endmodule

// File: rtl/sinepwm_top.sv
module sinepwm_top
  import sinepwm_pkg::*;
#(
  parameter  int CNT_W = 8,
  parameter  int DEPTH = 256,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CMP_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic [CMP_W-1:0] wrData,
  output logic             pwmMain,
  output logic             pwmFixed,
  output logic             tableEnd,
  output logic             passToggle
);

  localparam int NUM_CH = 2;

  pwmStrobe_t                    strobe;
  logic                          wrapNow;
  logic [CNT_W-1:0]              cnt;
  logic [CNT_W-1:0]              nextCnt;
  logic [CNT_W-1:0]              periodAct;
  logic [IDX_W-1:0]              lastIdx;
  logic [IDX_W-1:0]              rdIdx;
  logic [CMP_W-1:0]              cmpA;
  logic [CMP_W-1:0]              cmpB;
  logic [NUM_CH-1:0][CMP_W-1:0]  cmpNext;
  logic [NUM_CH-1:0]             pwmVec;

  sinepwm_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .periodAct(periodAct), .lastIdx(lastIdx),
    .cnt(cnt), .nextCnt(nextCnt), .rdIdx(rdIdx), .strobe(strobe)
  );

  sinepwm_datapath #(.CNT_W(CNT_W), .CMP_W(CMP_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr),
    .wrData(wrData), .strobe(strobe), .rdIdx(rdIdx), .periodAct(periodAct),
    .lastIdx(lastIdx), .cmpA(cmpA), .cmpB(cmpB), .cmpNext(cmpNext),
    .tableEnd(tableEnd), .passToggle(passToggle)
  );

  assign wrapNow = strobe.wrap;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    sinepwm_chan #(.CNT_W(CNT_W), .CMP_W(CMP_W)) uChan (
      .clk(clk), .rstN(rstN), .setNow(wrapNow), .nextCnt(nextCnt),
      .cmpNext(cmpNext[ch]), .pwm(pwmVec[ch])
    );
  end

  assign pwmMain  = pwmVec[0];
  assign pwmFixed = pwmVec[1];

endmodule

// File: rtl/sinepwm_chk.sv
module sinepwm_chk #(
  parameter int CNT_W = 8,
  parameter int CMP_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] periodAct,
  input logic [CMP_W-1:0] cmpA,
  input logic             wrap,
  input logic             pwmA,
  input logic             evPulse,
  input logic             passTog
);

  logic [CMP_W-1:0] cntWide;
  logic [CMP_W-1:0] perWide;
  assign cntWide = {{(CMP_W-CNT_W){1'b0}}, cnt};
  assign perWide = {{(CMP_W-CNT_W){1'b0}}, periodAct};

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= periodAct);

  assert_wrap_restart_R1: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (cnt == '0));

  assert_low_after_cmp_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cntWide >= cmpA) |-> !pwmA);

  assert_high_before_cmp_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cntWide < cmpA) |-> pwmA);

  assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> $stable(cmpA));

  assert_zero_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmpA == '0) |-> !pwmA);

  assert_above_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmpA > perWide) |-> pwmA);

  assert_toggle_event_R8: assert property (@(posedge clk) disable iff (!rstN)
    (passTog != $past(passTog)) == evPulse);

endmodule

bind sinepwm_top sinepwm_chk #(.CNT_W(CNT_W), .CMP_W(CMP_W)) uChk (
  .clk(clk), .rstN(rstN), .cnt(cnt), .periodAct(periodAct), .cmpA(cmpA),
  .wrap(wrapNow), .pwmA(pwmMain), .evPulse(tableEnd), .passTog(passToggle)
);

// File: tb/tb_sinepwm_top.sv
module tb_sinepwm_top;

  localparam int CNT_W = 8;
  localparam int DEPTH = 256;
  localparam int IDX_W = 8;
  localparam int CMP_W = 9;

  logic             clk = 1'b0;
  logic             rstN;
  logic             wrEn;
  logic [1:0]       wrSel;
  logic [IDX_W-1:0] wrAddr;
  logic [CMP_W-1:0] wrData;
  logic             pwmMain, pwmFixed, tableEnd, passToggle;

  sinepwm_top #(.CNT_W(CNT_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr),
    .wrData(wrData), .pwmMain(pwmMain), .pwmFixed(pwmFixed),
    .tableEnd(tableEnd), .passToggle(passToggle)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic  a;
    logic  b;
    logic  ev;
    logic  tog;
    string tag;
  } exp_t;

  exp_t  expQ[$];
  int    checks = 0;
  int    errors = 0;
  string curTag = "R10";

  // reference model built from the requirements
  int mCnt, mPerReg, mPerAct, mCmpA, mCmpB, mFixReg, mIdx, mLast;
  bit mInLast, mA, mB, mEv, mTog;
  int mMem [DEPTH];

  always @(posedge clk) begin
    bit   wrapM;
    int   nxt;
    exp_t e;
    if (!rstN) begin
      mCnt = 0; mPerReg = 255; mPerAct = 255; mCmpA = 0; mCmpB = 0;
      mFixReg = 0; mIdx = 0; mLast = DEPTH - 1; mInLast = 0;
      mA = 0; mB = 0; mEv = 0; mTog = 0;
    end else begin
      wrapM = (mCnt == mPerAct);
      nxt   = wrapM ? 0 : mCnt + 1;
      if (wrapM) begin
        mPerAct = mPerReg;
        mCmpA   = mMem[mIdx];
        mCmpB   = mFixReg;
        mEv     = mInLast;
        if (mInLast) mTog = ~mTog;
        mInLast = (mIdx >= mLast);
        mIdx    = mInLast ? 0 : mIdx + 1;
      end else begin
        mEv = 0;
      end
      if (nxt == mCmpA) mA = 0; else if (wrapM) mA = 1;
      if (nxt == mCmpB) mB = 0; else if (wrapM) mB = 1;
      mCnt = nxt;
      if (wrEn) begin
        case (wrSel)
          2'd0: mPerReg = int'(wrData) & 255;
          2'd1: mFixReg = int'(wrData);
          2'd2: mLast   = int'(wrData) & 255;
          default: mMem[wrAddr] = int'(wrData);
        endcase
      end
    end
    e.a = mA; e.b = mB; e.ev = mEv; e.tog = mTog; e.tag = curTag;
    expQ.push_back(e);
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  // monitor: one expectation per cycle, sampled at the falling edge
  always @(negedge clk) begin
    exp_t e;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      check(pwmMain, e.a, e.tag, "pwmMain");
      check(pwmFixed, e.b, (e.tag == "R10") ? "R10" : "R9", "pwmFixed");
      check(tableEnd, e.ev, (e.tag == "R10") ? "R10" : "R7", "tableEnd");
      check(passToggle, e.tog, (e.tag == "R10") ? "R10" : "R8", "passToggle");
    end
  end

  // driver: R11 encodings (0 period, 1 fixed compare, 2 last index, 3 sample)
  task automatic writeReg(input int sel, input int addr, input int val);
    wrEn   = 1'b1;
    wrSel  = 2'(sel);
    wrAddr = IDX_W'(addr);
    wrData = CMP_W'(val);
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrSel = '0; wrAddr = '0; wrData = '0;
    curTag = "R10";
    idle(4);
    rstN = 1'b1;
    // first period: loads only at the first wrap (R10)
    writeReg(3, 0, 64);
    writeReg(3, 1, 128);
    writeReg(2, 0, 1);
    writeReg(1, 0, 32);
    idle(200);
    curTag = "R2";     // default 256-clock period
    idle(400);
    curTag = "R3";
    idle(300);
    curTag = "R4";     // mid-period writes held until the wrap
    writeReg(3, 0, 200);
    writeReg(1, 0, 100);
    writeReg(0, 0, 40);
    idle(600);
    curTag = "R1";
    writeReg(0, 0, 15);
    writeReg(3, 0, 3);
    writeReg(3, 1, 9);
    writeReg(1, 0, 7);
    idle(200);
    curTag = "R5";     // zero and above-period compares
    writeReg(3, 0, 0);
    writeReg(3, 1, 4);
    writeReg(3, 2, 16);
    writeReg(3, 3, 15);
    writeReg(3, 4, 8);
    writeReg(2, 0, 4);
    writeReg(1, 0, 0);
    idle(250);
    writeReg(1, 0, 300);
    idle(100);
    curTag = "R11";
    writeReg(0, 0, 7);
    writeReg(1, 0, 3);
    idle(120);
    curTag = "R6";     // shrink to one entry mid-pass, then full 256 entries
    writeReg(2, 0, 0);
    idle(60);
    writeReg(0, 0, 3);
    for (int i = 0; i < DEPTH; i++) writeReg(3, i, i % 5);
    writeReg(2, 0, 255);
    idle(2200);
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule